// File: doc/BRIEF.md
# UART Baud and Bit-Timing Generator

This block turns a fast input clock into the bit timing a UART needs. A 16-bit divisor, loaded as two byte-wide latches through a small write port, divides the input clock into a single-cycle baud tick enable. The block then counts those ticks into bit periods of either 16 or 13 ticks. It gives a mid-bit sample strobe for the receiver and a bit-boundary strobe for the transmitter. The receive counter can be restarted so that it lines up with a detected start edge. The transmit counter runs freely.

Software chooses the divisor as input clock frequency / (ticks per bit × baud rate), rounded down. Software loads both latches during initialisation. Until the divisor is nonzero, the generator stays stopped. Each latch write holds the bus for two cycles while the baud counter restarts. A pending oversampling mode is adopted only at bit boundaries.

Top module: `uart_bitclk_gen`

## Requirements
- R1: After reset, bus_wait, bclk_tick, rx_sample and tx_bit_edge are low, both divisor latches are zero and the mode is 16 ticks per bit.
- R2: While the combined divisor is zero, no bclk_tick is produced.
- R3: With divisor N ≥ 1 and bus_wait low, bclk_tick pulses once every N clocks. The first pulse comes in the N-th cycle after bus_wait falls, so N = 1 gives a pulse every cycle.
- R4: An accepted write with wr_sel 0 or 1 raises bus_wait for exactly the two cycles that follow it. A write with wr_sel 2 raises no wait. A write with wr_sel 3 has no effect.
- R5: No bclk_tick occurs while bus_wait is high, and the baud count restarts from zero.
- R6: A write presented while bus_wait is high is ignored.
- R7: With mode bit 0 (wr_data[0] of a wr_sel 2 write) clear, a bit lasts 16 ticks. rx_sample fires on the 8th tick and tx_bit_edge on the 16th.
- R8: With mode bit 0 set, a bit lasts 13 ticks. rx_sample fires on the 6th tick and tx_bit_edge on the 13th.
- R9: rx_restart clears the receive tick count and suppresses rx_sample in that cycle. The following tick is the first tick of a new bit, and the pending mode is adopted.
- R10: A mode write takes effect at the next bit boundary of each counter, so a bit in progress keeps its length.
- R11: wr_sel 1 loads divisor bits 15:8 and wr_sel 0 loads bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UART input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | 0 low latch, 1 high latch, 2 mode, 3 unused |
| wr_data | input | 8 | Write data; bit 0 is the mode for wr_sel 2 |
| bus_wait | output | 1 | Bus hold during divisor reload |
| rx_restart | input | 1 | Realign receive bit timing |
| bclk_tick | output | 1 | Baud tick enable |
| rx_sample | output | 1 | Receive mid-bit sample strobe |
| tx_bit_edge | output | 1 | Transmit bit-boundary strobe |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor, two wait cycles, and 16 or 13 ticks per bit. It loads small divisors (1, 4, 256 and zero), which keeps whole bit periods, mode switches and restarts within a few hundred cycles. The 256 divisor needs the high latch, so it exercises the byte split. A value written during the wait window that would visibly change the tick rate shows whether the write is ignored.

// File: rtl/uart_bitclk_gen.sv
module uart_bitclk_gen #(
  parameter int DIV_W    = 16,
  parameter int WAIT_CYC = 2,
  parameter int OS_SLOW  = 16,
  parameter int OS_FAST  = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic       bus_wait,
  input  logic       rx_restart,
  output logic       bclk_tick,
  output logic       rx_sample,
  output logic       tx_bit_edge
);
  localparam int BYTE_W = DIV_W / 2;
  localparam int PH_W   = $clog2(OS_SLOW);
  localparam int WT_W   = $clog2(WAIT_CYC + 1);
  localparam logic [PH_W-1:0] TOP_SLOW = PH_W'(OS_SLOW - 1);
  localparam logic [PH_W-1:0] TOP_FAST = PH_W'(OS_FAST - 1);
  localparam logic [PH_W-1:0] MID_SLOW = PH_W'(OS_SLOW / 2 - 1);
  localparam logic [PH_W-1:0] MID_FAST = PH_W'(OS_FAST / 2 - 1);

  logic [BYTE_W-1:0] div_lo, div_hi;
  logic [DIV_W-1:0]  divisor, baud_cnt;
  logic [WT_W-1:0]   wait_cnt;
  logic [PH_W-1:0]   tx_ph, rx_ph;
  logic              mode_req, tx_fast, rx_fast;

  assign divisor = {div_hi, div_lo};
  assign bus_wait = (wait_cnt != '0);

  wire wr_ok    = wr_en && !bus_wait;
  wire latch_wr = wr_ok && (wr_sel == 2'd0 || wr_sel == 2'd1);
  wire mode_wr  = wr_ok && (wr_sel == 2'd2);

  assign bclk_tick = (divisor != '0) && !bus_wait && (baud_cnt == divisor - DIV_W'(1));

  wire [PH_W-1:0] tx_top = tx_fast ? TOP_FAST : TOP_SLOW;
  wire [PH_W-1:0] rx_top = rx_fast ? TOP_FAST : TOP_SLOW;
  wire [PH_W-1:0] rx_mid = rx_fast ? MID_FAST : MID_SLOW;
  wire tx_end = bclk_tick && (tx_ph == tx_top);
  wire rx_end = bclk_tick && (rx_ph == rx_top);

  assign tx_bit_edge = tx_end;
  assign rx_sample   = bclk_tick && !rx_restart && (rx_ph == rx_mid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lo   <= '0;
      div_hi   <= '0;
      mode_req <= 1'b0;
    end else if (latch_wr) begin
      if (wr_sel[0]) div_hi <= wr_data[BYTE_W-1:0];
      else           div_lo <= wr_data[BYTE_W-1:0];
    end else if (mode_wr) begin
      mode_req <= wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wait_cnt <= '0;
    else if (latch_wr) wait_cnt <= WT_W'(WAIT_CYC);
    else if (bus_wait) wait_cnt <= wait_cnt - WT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      baud_cnt <= '0;
    else if (latch_wr || bus_wait || divisor == '0 || bclk_tick)
      baud_cnt <= '0;
    else
      baud_cnt <= baud_cnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ph   <= '0;
      tx_fast <= 1'b0;
    end else if (tx_end) begin
      tx_ph   <= '0;
      tx_fast <= mode_req;
    end else if (bclk_tick) begin
      tx_ph   <= tx_ph + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ph   <= '0;
      rx_fast <= 1'b0;
    end else if (rx_restart || rx_end) begin
      rx_ph   <= '0;
      rx_fast <= mode_req;
    end else if (bclk_tick) begin
      rx_ph   <= rx_ph + PH_W'(1);
    end
  end
endmodule

// File: rtl/uart_bitclk_gen_chk.sv
module uart_bitclk_gen_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             latch_wr,
  input logic [DIV_W-1:0] divisor,
  input logic             bus_wait,
  input logic             rx_restart,
  input logic             bclk_tick,
  input logic             rx_sample,
  input logic             tx_bit_edge
);
  a_r2_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |-> !bclk_tick);

  a_r3_unit_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == DIV_W'(1) && !bus_wait) |-> bclk_tick);

  a_r3_spaced_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_tick && divisor > DIV_W'(1)) |=> !bclk_tick);

  a_r4_two_wait: assert property (@(posedge clk) disable iff (!rst_n)
    latch_wr |=> bus_wait ##1 bus_wait ##1 !bus_wait);

  a_r4_wait_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wait) |-> $past(latch_wr));

  a_r5_quiet_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |-> !bclk_tick);

  a_r7_strobes_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sample || tx_bit_edge) |-> bclk_tick);

  a_r9_restart_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
    rx_restart |-> !rx_sample);
endmodule

bind uart_bitclk_gen uart_bitclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .latch_wr(latch_wr), .divisor(divisor),
  .bus_wait(bus_wait), .rx_restart(rx_restart), .bclk_tick(bclk_tick),
  .rx_sample(rx_sample), .tx_bit_edge(tx_bit_edge)
);

// File: tb/uart_bitclk_gen_bench.sv
module uart_bitclk_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic rx_restart = 1'b0;
  logic bus_wait, bclk_tick, rx_sample, tx_bit_edge;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_lo, m_hi, m_wait, m_cnt, m_txph, m_rxph, m_req, m_txf, m_rxf;
  int idx, ticks, last_tx, tx_gap, rx_first;
  bit tx_now;

  always #4 clk = ~clk;

  uart_bitclk_gen u_uart_bitclk_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .bus_wait(bus_wait), .rx_restart(rx_restart), .bclk_tick(bclk_tick),
    .rx_sample(rx_sample), .tx_bit_edge(tx_bit_edge)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [1:0] sel, input logic [7:0] d, input logic rs);
    int div, ttx, trx;
    bit e_tick, e_wait, e_tx, e_rx, acc, lw;
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; rx_restart = rs;
    #1;
    div    = m_hi * 256 + m_lo;
    ttx    = m_txf ? 13 : 16;
    trx    = m_rxf ? 13 : 16;
    e_wait = (m_wait != 0);
    e_tick = (div != 0) && !e_wait && (m_cnt == div - 1);
    e_tx   = e_tick && (m_txph == ttx - 1);
    e_rx   = e_tick && !rs && (m_rxph == (m_rxf ? 5 : 7));
    check(bclk_tick == e_tick,  "R3", "bclk_tick", bclk_tick, e_tick);
    check(bus_wait == e_wait,   "R4", "bus_wait", bus_wait, e_wait);
    check(tx_bit_edge == e_tx,  "R7", "tx_bit_edge", tx_bit_edge, e_tx);
    check(rx_sample == e_rx,    "R9", "rx_sample", rx_sample, e_rx);
    idx++;
    if (bclk_tick) ticks++;
    tx_now = tx_bit_edge;
    if (tx_bit_edge) begin tx_gap = idx - last_tx; last_tx = idx; end
    if (rx_sample && rx_first < 0) rx_first = idx;
    @(posedge clk);
    acc = we && !e_wait;
    lw  = acc && (sel < 2);
    m_cnt  = (lw || e_wait || div == 0 || e_tick) ? 0 : m_cnt + 1;
    m_wait = lw ? 2 : (m_wait > 0 ? m_wait - 1 : 0);
    if (e_tick) begin
      if (m_txph == ttx - 1) begin m_txph = 0; m_txf = m_req; end
      else m_txph++;
    end
    if (rs) begin m_rxph = 0; m_rxf = m_req; end
    else if (e_tick) begin
      if (m_rxph == trx - 1) begin m_rxph = 0; m_rxf = m_req; end
      else m_rxph++;
    end
    if (acc && sel == 2'd0) m_lo = d;
    if (acc && sel == 2'd1) m_hi = d;
    if (acc && sel == 2'd2) m_req = d[0];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'd0, 1'b0);
  endtask

  task automatic wait_tx();
    int n = 0;
    do begin cyc(1'b0, 2'd0, 8'd0, 1'b0); n++; end while (!tx_now && n < 80);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int r0;
    m_lo = 0; m_hi = 0; m_wait = 0; m_cnt = 0; m_txph = 0; m_rxph = 0;
    m_req = 0; m_txf = 0; m_rxf = 0;
    idx = 0; ticks = 0; last_tx = 0; tx_gap = 0; rx_first = -1; tx_now = 0;
    repeat (3) @(negedge clk);
    #1;
    check(!bus_wait && !bclk_tick && !rx_sample && !tx_bit_edge, "R1", "outputs in reset",
          {bus_wait, bclk_tick, rx_sample, tx_bit_edge}, 0);
    rst_n = 1'b1;

    // R1 / R2: latches clear after reset, so the generator is stopped
    ticks = 0; idle(20);
    check(ticks == 0, "R2", "ticks with zero divisor", ticks, 0);

    // R3: divisor 1 ticks every cycle once the wait clears
    cyc(1'b1, 2'd0, 8'd1, 1'b0); idle(2);
    ticks = 0; idle(10);
    check(ticks == 10, "R3", "ticks with divisor 1", ticks, 10);

    // R7: 16x timing after a restart
    cyc(1'b0, 2'd0, 8'd0, 1'b1); r0 = idx; rx_first = -1;
    idle(20);
    check(rx_first == r0 + 8, "R7", "16x sample index", rx_first - r0, 8);
    wait_tx(); wait_tx();
    check(tx_gap == 16, "R7", "16x tx bit period", tx_gap, 16);

    // R10: mode write mid-bit keeps current bit at 16, next at 13
    idle(3);
    cyc(1'b1, 2'd2, 8'd1, 1'b0);
    check(!bus_wait, "R4", "no wait after mode write", bus_wait, 0);
    wait_tx();
    check(tx_gap == 16, "R10", "bit in progress length", tx_gap, 16);
    wait_tx();
    check(tx_gap == 13, "R8", "13x tx bit period", tx_gap, 13);

    // R8 / R9: restart adopts 13x, sample on 6th tick
    cyc(1'b0, 2'd0, 8'd0, 1'b1); r0 = idx; rx_first = -1;
    idle(16);
    check(rx_first == r0 + 6, "R9", "13x sample index after restart", rx_first - r0, 6);

    // R4: unused select has no effect on timing
    cyc(1'b1, 2'd3, 8'd7, 1'b0);
    ticks = 0; idle(5);
    check(ticks == 5, "R4", "ticks after unused select", ticks, 5);

    // R6: write during wait ignored (divisor stays 4)
    cyc(1'b1, 2'd0, 8'd4, 1'b0);
    cyc(1'b1, 2'd0, 8'd1, 1'b0);
    idle(1);
    ticks = 0; idle(20);
    check(ticks == 5, "R6", "ticks after write in wait", ticks, 5);

    // R11: high latch supplies bits 15:8 -> divisor 256
    cyc(1'b1, 2'd1, 8'd1, 1'b0); idle(2);
    cyc(1'b1, 2'd0, 8'd0, 1'b0); idle(2);
    ticks = 0; idle(300);
    check(ticks == 1, "R11", "ticks with divisor 256 in 300 cycles", ticks, 1);

    // R2: back to zero stops the generator; R5 via per-cycle wait compare
    cyc(1'b1, 2'd1, 8'd0, 1'b0); idle(2);
    ticks = 0; idle(30);
    check(ticks == 0, "R2", "ticks after divisor cleared", ticks, 0);
    check(m_wait == 0 && !bus_wait, "R5", "wait released", bus_wait, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule